// File: doc/BRIEF.md
# Packed Double-Precision Compare Unit

This block compares up to eight pairs of IEEE-754 binary64 values side by side and turns the per-lane results into one of two destination forms. Each 64-bit lane sorts its operand pair into exactly one of four outcomes: greater, less, equal or unordered. A 5-bit condition code then picks which outcomes count as true. The same lane also reports whether the comparison raises the invalid-operation condition.

The results reach the outside in one of two ways. In bit-mask form they become one bit per lane. This form supports a zeroing writemask and can broadcast the low element of the second operand to every lane. In lane-mask form each 64-bit lane becomes all ones or all zeros. Bits beyond the vector length are then either cleared, or, in the legacy 128-bit form, taken from the old destination value.

The datapath is combinational. A parameter can add one output register stage with a synchronous reset.

Top module: `vcmp_packed`

## Requirements
- R1: Each lane classifies its pair (a from `src_a`, b from `src_b`, lane j at bits [64j+63:64j]) as exactly one of greater, less, equal or unordered. A NaN is an exponent of all ones with a nonzero fraction, and any NaN makes the pair unordered. +0 and -0 are equal. Subnormals are ordered by value.
- R2: The condition code is decoded as follows:
  - `pred[1:0]` picks the base relation: 0 = equal, 1 = less, 2 = less-or-equal, 3 = unordered.
  - `pred[2]` inverts all four outcomes.
  - `pred[3]` toggles only the unordered outcome.
  - `pred[4]` has no effect on the result.
- R3: With `out_mode`=0 (bit-mask form), `kmask_out[j]` is 1 when lane j's condition holds and 0 when it does not, and `dest_out` is all zeros.
- R4: In bit-mask form with `wmask_en`=1, a lane whose `wmask` bit is 0 reads 0 in `kmask_out`. With `wmask_en`=0, `wmask` has no effect.
- R5: `vlen_sel` gives the active lane count: 0 gives 2 lanes, 1 gives 4, and 2 or 3 give 8. Mask bits at or above the active count are 0.
- R6: In bit-mask form, `bcast_en`=1 makes every lane compare against `src_b[63:0]`. In the lane-mask forms, `bcast_en`, `wmask` and `wmask_en` have no effect.
- R7: With `out_mode`=1 or 3 (lane-mask form), each active 64-bit lane of `dest_out` is all ones when its condition holds and all zeros when it does not. Lanes beyond the vector length are zero, and `kmask_out` is zero.
- R8: With `out_mode`=2 (legacy form), exactly two lanes are active whatever `vlen_sel` says. Only `pred[2:0]` is used, with `pred[4:3]` taken as 0. Bits 511:128 of `dest_out` equal those of `dest_old`.
- R9: A lane is invalid when either operand is a signaling NaN (quiet bit 51 clear). It is also invalid when the pair is unordered and the condition is signaling, which is the case when `pred[0]^pred[1]^pred[4]` is 1.
- R10: `invalid_out` is the OR of lane invalid flags over active lanes only. A lane is inactive when it lies beyond the vector length or, in bit-mask form, when it is cleared by the writemask.
- R11: With OUT_REG=1, every output reflects the inputs one clock later, and a synchronous active-high `rst` clears all outputs. With OUT_REG=0, the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset |
| src_a | input | 512 | First operand vector, lane j at bits [64j+63:64j] |
| src_b | input | 512 | Second operand vector |
| pred | input | 5 | Condition code |
| vlen_sel | input | 2 | Vector length select: 0=128, 1=256, 2/3=512 bits |
| out_mode | input | 2 | 0 bit-mask, 1/3 lane-mask zeroing, 2 legacy lane-mask |
| wmask | input | 8 | Per-lane writemask |
| wmask_en | input | 1 | Enables the writemask in bit-mask form |
| bcast_en | input | 1 | Broadcast of src_b[63:0] in bit-mask form |
| dest_old | input | 512 | Previous destination value |
| dest_out | output | 512 | Lane-mask destination |
| kmask_out | output | 8 | Bit-mask destination |
| invalid_out | output | 1 | Invalid-operation flag of the active lanes |

## Verification
Signed zeros, negative pairs, subnormals and infinities are checked against each other. A design that compared raw bit patterns would either call +0 and -0 unequal or reverse the order of negative numbers.

Quiet and signaling NaNs are run under condition codes that differ only in bit 4 or bit 3. A design that mixed up the signaling rule, or let `pred[3]` through in legacy form, would flip the invalid flag or the result of that lane.

A NaN is placed in a lane that is then switched off by vector length or by the writemask. This exposes a flag leaking from an inactive lane.

Broadcast and the writemask are also applied in lane-mask form, where they must change nothing. The old destination must still come through in legacy form.

// File: rtl/vcmp_pkg.sv
`timescale 1ns/1ps
package vcmp_pkg;

    localparam int FP_W = 64;

    typedef enum logic [1:0] {
        OUT_KMASK    = 2'd0,
        OUT_LANE     = 2'd1,
        OUT_LEGACY   = 2'd2,
        OUT_LANE_ALT = 2'd3
    } out_mode_e;

    // Outcome of one lane, one-hot: greater, less, equal, unordered
    typedef struct packed {
        logic gt;
        logic lt;
        logic eq;
        logic un;
    } rel_t;

    function automatic logic is_nan(input logic [FP_W-1:0] x);
        return (&x[62:52]) && (|x[51:0]);
    endfunction

    function automatic logic is_snan(input logic [FP_W-1:0] x);
        return is_nan(x) && !x[51];
    endfunction

    function automatic rel_t fp_relate(input logic [FP_W-1:0] a, input logic [FP_W-1:0] b);
        rel_t r;
        logic both_zero;
        logic mag_lt;
        r         = '0;
        both_zero = ~|a[62:0] && ~|b[62:0];
        mag_lt    = a[62:0] < b[62:0];
        if (is_nan(a) || is_nan(b)) begin
            r.un = 1'b1;
        end else if (both_zero || (a == b)) begin
            r.eq = 1'b1;
        end else begin
            if (a[63] != b[63])
                r.lt = a[63];
            else if (!a[63])
                r.lt = mag_lt;
            else
                r.lt = !mag_lt;
            r.gt = !r.lt;
        end
        return r;
    endfunction

    // Set of outcomes that make the condition true, same bit order as rel_t
    function automatic logic [3:0] pred_accept(input logic [3:0] p);
        logic [3:0] m;
        case (p[1:0])
            2'd0:    m = 4'b0010;
            2'd1:    m = 4'b0100;
            2'd2:    m = 4'b0110;
            default: m = 4'b0001;
        endcase
        if (p[2]) m = ~m;
        if (p[3]) m[0] = ~m[0];
        return m;
    endfunction

    function automatic logic pred_signals(input logic [4:0] p);
        return p[0] ^ p[1] ^ p[4];
    endfunction

    function automatic int unsigned active_lanes(input logic [1:0] mode,
                                                 input logic [1:0] vlen,
                                                 input int unsigned cap);
        int unsigned n;
        if (mode == OUT_LEGACY) begin
            n = 2;
        end else begin
            case (vlen)
                2'd0:    n = 2;
                2'd1:    n = 4;
                default: n = 8;
            endcase
        end
        return (n > cap) ? cap : n;
    endfunction

endpackage

// File: rtl/vcmp_lane.sv
`timescale 1ns/1ps
module vcmp_lane
    import vcmp_pkg::*;
(
    input  logic [FP_W-1:0] a,
    input  logic [FP_W-1:0] b,
    input  logic [4:0]      pred,
    output logic            hit,
    output logic            inv
);

    rel_t rel;

    always_comb begin
        rel = fp_relate(a, b);
        hit = |(pred_accept(pred[3:0]) & rel);
        inv = is_snan(a) | is_snan(b) | (rel.un & pred_signals(pred));
    end

endmodule

// File: rtl/vcmp_format.sv
`timescale 1ns/1ps
module vcmp_format
    import vcmp_pkg::*;
#(
    parameter int LANES = 8
)(
    input  logic [LANES-1:0]      lane_hit,
    input  logic [LANES-1:0]      lane_inv,
    input  logic [1:0]            out_mode,
    input  logic [1:0]            vlen_sel,
    input  logic [LANES-1:0]      wmask,
    input  logic                  wmask_en,
    input  logic [LANES*FP_W-1:0] dest_old,
    output logic [LANES*FP_W-1:0] dest,
    output logic [LANES-1:0]      kmask,
    output logic                  invalid
);

    int unsigned      n_act;
    logic             is_k;
    logic             is_leg;
    logic [LANES-1:0] in_len;
    logic [LANES-1:0] wr_en;
    logic [LANES-1:0] active;

    always_comb n_act = active_lanes(out_mode, vlen_sel, LANES);

    assign is_k   = (out_mode == OUT_KMASK);
    assign is_leg = (out_mode == OUT_LEGACY);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign in_len[j] = (unsigned'(j) < n_act);
        assign dest[j*FP_W +: FP_W] =
            is_k       ? '0 :
            in_len[j]  ? {FP_W{lane_hit[j]}} :
            is_leg     ? dest_old[j*FP_W +: FP_W] : '0;
    end

    assign wr_en   = (is_k && wmask_en) ? wmask : '1;
    assign active  = in_len & wr_en;
    assign kmask   = is_k ? (lane_hit & active) : '0;
    assign invalid = |(lane_inv & active);

endmodule

// File: rtl/vcmp_packed.sv
`timescale 1ns/1ps
module vcmp_packed
    import vcmp_pkg::*;
#(
    parameter int LANES   = 8,
    parameter bit OUT_REG = 1'b0
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LANES*FP_W-1:0] src_a,
    input  logic [LANES*FP_W-1:0] src_b,
    input  logic [4:0]            pred,
    input  logic [1:0]            vlen_sel,
    input  logic [1:0]            out_mode,
    input  logic [LANES-1:0]      wmask,
    input  logic                  wmask_en,
    input  logic                  bcast_en,
    input  logic [LANES*FP_W-1:0] dest_old,
    output logic [LANES*FP_W-1:0] dest_out,
    output logic [LANES-1:0]      kmask_out,
    output logic                  invalid_out
);

    localparam int VW = LANES * FP_W;

    logic [4:0]       lane_pred;
    logic             bcast_live;
    logic [LANES-1:0] lane_hit;
    logic [LANES-1:0] lane_inv;
    logic [VW-1:0]    fmt_dest;
    logic [LANES-1:0] fmt_kmask;
    logic             fmt_inv;

    // Legacy form sees only the low three condition bits
    assign lane_pred  = (out_mode == OUT_LEGACY) ? {2'b00, pred[2:0]} : pred;
    assign bcast_live = bcast_en && (out_mode == OUT_KMASK);

    for (genvar j = 0; j < LANES; j++) begin : g_cmp
        logic [FP_W-1:0] b_sel;
        assign b_sel = bcast_live ? src_b[FP_W-1:0] : src_b[j*FP_W +: FP_W];
        vcmp_lane u_lane (
            .a    (src_a[j*FP_W +: FP_W]),
            .b    (b_sel),
            .pred (lane_pred),
            .hit  (lane_hit[j]),
            .inv  (lane_inv[j])
        );
    end

    vcmp_format #(.LANES(LANES)) u_fmt (
        .lane_hit (lane_hit),
        .lane_inv (lane_inv),
        .out_mode (out_mode),
        .vlen_sel (vlen_sel),
        .wmask    (wmask),
        .wmask_en (wmask_en),
        .dest_old (dest_old),
        .dest     (fmt_dest),
        .kmask    (fmt_kmask),
        .invalid  (fmt_inv)
    );

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                dest_out    <= '0;
                kmask_out   <= '0;
                invalid_out <= 1'b0;
            end else begin
                dest_out    <= fmt_dest;
                kmask_out   <= fmt_kmask;
                invalid_out <= fmt_inv;
            end
        end
    end else begin : g_comb
        assign dest_out    = fmt_dest;
        assign kmask_out   = fmt_kmask;
        assign invalid_out = fmt_inv;
    end

endmodule

// File: rtl/vcmp_packed_chk.sv
`timescale 1ns/1ps
module vcmp_packed_chk
    import vcmp_pkg::*;
#(
    parameter int LANES   = 8,
    parameter bit OUT_REG = 1'b0
)(
    input logic                  clk,
    input logic                  rst,
    input logic [1:0]            out_mode,
    input logic [1:0]            vlen_sel,
    input logic [LANES-1:0]      wmask,
    input logic                  wmask_en,
    input logic [LANES*FP_W-1:0] dest_old,
    input logic [LANES*FP_W-1:0] fmt_dest,
    input logic [LANES-1:0]      fmt_kmask,
    input logic                  fmt_inv,
    input logic [LANES*FP_W-1:0] dest_out,
    input logic [LANES-1:0]      kmask_out,
    input logic                  invalid_out
);

    localparam int VW = LANES * FP_W;

    p_wmask_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (out_mode == 2'd0 && wmask_en) |-> ((fmt_kmask & ~wmask) == '0));

    p_inv_masked_r10: assert property (@(posedge clk) disable iff (rst)
        (out_mode == 2'd0 && wmask_en && wmask == '0) |-> !fmt_inv);

    p_kmask_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (out_mode != 2'd0) |-> (fmt_kmask == '0));

    p_dest_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (out_mode == 2'd0) |-> (fmt_dest == '0));

    if (LANES > 2) begin : g_upper
        p_kmask_upper_r5: assert property (@(posedge clk) disable iff (rst)
            (out_mode == 2'd0 && vlen_sel == 2'd0) |-> (fmt_kmask[LANES-1:2] == '0));

        p_lane_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
            (out_mode[0] && vlen_sel == 2'd0) |-> (fmt_dest[VW-1:2*FP_W] == '0));

        p_legacy_keep_r8: assert property (@(posedge clk) disable iff (rst)
            (out_mode == 2'd2) |-> (fmt_dest[VW-1:2*FP_W] == dest_old[VW-1:2*FP_W]));
    end

    if (OUT_REG) begin : g_reg_chk
        p_reg_follow_r11: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (kmask_out == $past(fmt_kmask) && invalid_out == $past(fmt_inv)
                      && dest_out == $past(fmt_dest)));
    end else begin : g_comb_chk
        p_comb_follow_r11: assert property (@(posedge clk) disable iff (rst)
            (kmask_out == fmt_kmask && invalid_out == fmt_inv && dest_out == fmt_dest));
    end

endmodule

bind vcmp_packed vcmp_packed_chk #(.LANES(LANES), .OUT_REG(OUT_REG)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .out_mode    (out_mode),
    .vlen_sel    (vlen_sel),
    .wmask       (wmask),
    .wmask_en    (wmask_en),
    .dest_old    (dest_old),
    .fmt_dest    (fmt_dest),
    .fmt_kmask   (fmt_kmask),
    .fmt_inv     (fmt_inv),
    .dest_out    (dest_out),
    .kmask_out   (kmask_out),
    .invalid_out (invalid_out)
);

// File: tb/vcmp_packed_tb.sv
`timescale 1ns/1ps
module vcmp_packed_tb;

    localparam int LANES = 8;
    localparam int VW    = LANES * 64;

    localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] TWO  = 64'h4000_0000_0000_0000;
    localparam logic [63:0] NEG1 = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] NEG2 = 64'hC000_0000_0000_0000;
    localparam logic [63:0] PZ   = 64'h0000_0000_0000_0000;
    localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;
    localparam logic [63:0] QN   = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] SN   = 64'h7FF0_0000_0000_0001;
    localparam logic [63:0] DEN  = 64'h0000_0000_0000_0001;
    localparam logic [63:0] INF  = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] FILL = 64'hA5A5_A5A5_A5A5_A5A5;
    localparam logic [63:0] ONES = '1;

    typedef struct packed {
        logic [63:0] a;
        logic [63:0] b;
        logic [4:0]  p;
        logic        hit;
        logic        inv;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{ONE,  TWO,  5'h01, 1'b1, 1'b0},
        '{TWO,  ONE,  5'h01, 1'b0, 1'b0},
        '{ONE,  ONE,  5'h02, 1'b1, 1'b0},
        '{PZ,   NZ,   5'h00, 1'b1, 1'b0},
        '{NEG1, ONE,  5'h01, 1'b1, 1'b0},
        '{NEG2, NEG1, 5'h01, 1'b1, 1'b0},
        '{NEG1, NEG2, 5'h0E, 1'b1, 1'b0},
        '{QN,   ONE,  5'h00, 1'b0, 1'b0},
        '{QN,   ONE,  5'h01, 1'b0, 1'b1},
        '{QN,   ONE,  5'h08, 1'b1, 1'b0},
        '{QN,   ONE,  5'h03, 1'b1, 1'b0},
        '{SN,   ONE,  5'h03, 1'b1, 1'b1},
        '{ONE,  QN,   5'h11, 1'b0, 1'b0},
        '{ONE,  QN,   5'h10, 1'b0, 1'b1},
        '{DEN,  PZ,   5'h0E, 1'b1, 1'b0},
        '{INF,  ONE,  5'h0D, 1'b1, 1'b0},
        '{ONE,  TWO,  5'h04, 1'b1, 1'b0},
        '{ONE,  ONE,  5'h0C, 1'b0, 1'b0},
        '{ONE,  QN,   5'h04, 1'b1, 1'b0},
        '{ONE,  QN,   5'h1F, 1'b1, 1'b1},
        '{ONE,  QN,   5'h0B, 1'b0, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [VW-1:0]    src_a, src_b, dest_old;
    logic [4:0]       pred;
    logic [1:0]       vlen_sel, out_mode;
    logic [LANES-1:0] wmask;
    logic             wmask_en, bcast_en;
    logic [VW-1:0]    dest_out;
    logic [LANES-1:0] kmask_out;
    logic             invalid_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    vcmp_packed #(.LANES(LANES), .OUT_REG(1'b1)) u_dut (
        .clk, .rst, .src_a, .src_b, .pred, .vlen_sel, .out_mode,
        .wmask, .wmask_en, .bcast_en, .dest_old,
        .dest_out, .kmask_out, .invalid_out
    );

    function automatic logic [VW-1:0] fill(input logic [63:0] x);
        return {LANES{x}};
    endfunction

    // even lanes TWO, odd lanes NEG1
    function automatic logic [VW-1:0] alt_b();
        logic [VW-1:0] v;
        for (int j = 0; j < LANES; j++) v[j*64 +: 64] = (j % 2 == 0) ? TWO : NEG1;
        return v;
    endfunction

    task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [VW-1:0] exp_d;
        src_a = fill(ONE); src_b = fill(TWO); pred = 5'h01;
        vlen_sel = 2'd2; out_mode = 2'd0; wmask = '0; wmask_en = 1'b0;
        bcast_en = 1'b0; dest_old = '0;
        repeat (3) step();
        // R11 reset state
        check("R11 reset kmask", VW'(kmask_out), '0);
        check("R11 reset dest", dest_out, '0);
        check("R11 reset invalid", VW'(invalid_out), '0);
        rst = 1'b0;

        // R1 R2 R9 table walk, all lanes identical, bit-mask form, 512 bits
        for (int i = 0; i < NV; i++) begin
            src_a = fill(VECS[i].a); src_b = fill(VECS[i].b); pred = VECS[i].p;
            step();
            check($sformatf("R1 R2 vec %0d kmask", i), VW'(kmask_out),
                  VECS[i].hit ? VW'(8'hFF) : '0);
            check($sformatf("R9 vec %0d invalid", i), VW'(invalid_out), VW'(VECS[i].inv));
        end

        // R3 per-lane independence
        src_a = fill(ONE); src_b = alt_b(); pred = 5'h01;
        step();
        check("R3 mixed lanes kmask", VW'(kmask_out), VW'(8'h55));
        check("R3 dest zero in bit-mask form", dest_out, '0);

        // R11 output holds until the next edge
        src_b = fill(TWO);
        #1;
        check("R11 registered hold", VW'(kmask_out), VW'(8'h55));
        step();
        check("R11 registered update", VW'(kmask_out), VW'(8'hFF));
        src_b = alt_b();
        step();

        // R4 writemask
        wmask = 8'h0F; wmask_en = 1'b1;
        step();
        check("R4 zeroing writemask", VW'(kmask_out), VW'(8'h05));
        wmask = 8'h00; wmask_en = 1'b0;
        step();
        check("R4 writemask disabled", VW'(kmask_out), VW'(8'h55));

        // R5 vector length
        vlen_sel = 2'd0;
        step();
        check("R5 128-bit lanes", VW'(kmask_out), VW'(8'h01));
        vlen_sel = 2'd1;
        step();
        check("R5 256-bit lanes", VW'(kmask_out), VW'(8'h05));
        vlen_sel = 2'd3;
        step();
        check("R5 code 3 is 512-bit", VW'(kmask_out), VW'(8'h55));

        // R6 broadcast
        bcast_en = 1'b1; vlen_sel = 2'd2;
        step();
        check("R6 broadcast kmask", VW'(kmask_out), VW'(8'hFF));

        // R7 lane-mask form, broadcast and writemask ignored (R6)
        out_mode = 2'd1; vlen_sel = 2'd1; dest_old = '1;
        wmask_en = 1'b1; wmask = 8'h00;
        step();
        exp_d = '0;
        for (int j = 0; j < 4; j++) exp_d[j*64 +: 64] = (j % 2 == 0) ? ONES : '0;
        check("R7 lane-mask 256 dest", dest_out, exp_d);
        check("R7 kmask idle", VW'(kmask_out), '0);
        out_mode = 2'd3; vlen_sel = 2'd2;
        step();
        exp_d = '0;
        for (int j = 0; j < LANES; j++) exp_d[j*64 +: 64] = (j % 2 == 0) ? ONES : '0;
        check("R6 R7 lane-mask ignores broadcast and writemask", dest_out, exp_d);
        bcast_en = 1'b0; wmask_en = 1'b0;

        // R8 legacy form
        out_mode = 2'd2; vlen_sel = 2'd2; dest_old = fill(FILL); pred = 5'h11;
        step();
        exp_d = fill(FILL);
        exp_d[63:0] = ONES; exp_d[127:64] = '0;
        check("R8 legacy keeps upper", dest_out, exp_d);
        src_a[63:0] = QN;
        step();
        check("R8 R9 legacy drops pred4, signaling", VW'(invalid_out), VW'(1'b1));
        out_mode = 2'd1;
        step();
        check("R9 pred4 makes LT quiet", VW'(invalid_out), '0);
        out_mode = 2'd2; pred = 5'h08;
        step();
        exp_d = fill(FILL); exp_d[127:0] = '0;
        check("R8 legacy ignores pred3", dest_out, exp_d);
        out_mode = 2'd1;
        step();
        check("R2 pred3 accepts unordered", dest_out[63:0], VW'(ONES));

        // R10 invalid scoped to active lanes
        src_a = fill(ONE); src_a[5*64 +: 64] = QN; src_b = fill(TWO); pred = 5'h01;
        out_mode = 2'd0; vlen_sel = 2'd0;
        step();
        check("R10 lane beyond length", VW'(invalid_out), '0);
        vlen_sel = 2'd2;
        step();
        check("R10 active lane flags", VW'(invalid_out), VW'(1'b1));
        check("R3 NaN lane false", VW'(kmask_out), VW'(8'hDF));
        wmask_en = 1'b1; wmask = 8'hDF;
        step();
        check("R10 writemasked lane", VW'(invalid_out), '0);
        out_mode = 2'd1;
        step();
        check("R6 R10 writemask ignored in lane form", VW'(invalid_out), VW'(1'b1));

        // R11 synchronous reset mid-run
        rst = 1'b1;
        step();
        check("R11 reset clears dest", dest_out, '0);
        check("R11 reset clears invalid", VW'(invalid_out), '0);
        rst = 1'b0;

        finish_run();
    end

endmodule